// File: doc/BRIEF.md
# Shared Microcode Store Arbiter

This block shares one microcode store between a DSP sequencer, which fetches instruction words, and a host processor that loads or patches those words. The sequencer forms a fetch address from a routine number and a step index within that routine. The host cannot reach the store directly. It writes byte-wide holding registers in a small memory-mapped window: a step register, a routine register and one register for each byte half of the word.

Writing the most significant data half arms a commit. The block then waits for a cycle in which the sequencer reports that it is not fetching. In that cycle it switches the address multiplexer to the held host address, disables the store's output, enables its write strobe and places the held data on the shared data bus. The host can therefore change coefficient words while a routine runs, and no sequencer fetch is disturbed.

The store itself is an internal behavioural model. It is built from byte-wide halves that are accessed side by side to form one word.

Top module: `ucode_share_ctrl`

## Requirements
- R1: After reset, `commit_pending` is 0, `ram_we_n` is 1 and `ram_oe_n` is 0.
- R2: The fetch address is `{seq_routine, seq_step}`, with the routine in bits 10:8. The word stored there appears on `seq_rdata` after the next rising clock edge.
- R3: A host write with `host_addr` in 0x0200 to 0x03FF selects a holding register by `host_addr[1:0]`, and the register map repeats throughout the window. Offset 0 is the step (8 bits). Offset 1 is the routine (bits 2:0 of the write data; upper bits are dropped). Offset 2 is data bits 7:0. Offset 3 is data bits 15:8.
- R4: A host write outside 0x0200 to 0x03FF changes no holding register and does not arm a commit.
- R5: A host write to offset 3 sets `commit_pending`, which is visible after that clock edge.
- R6: `ram_we_n` goes low only in a cycle where `seq_idle` is 1. While `seq_idle` is 0, a pending commit stays pending.
- R7: In a commit cycle (`commit_pending` and `seq_idle` both 1), `ram_we_n` is 0, `ram_oe_n` is 1 and `ram_addr` is `{routine register, step register}`.
- R8: After a commit cycle, `commit_pending` is 0 unless a new offset-3 write arrived in that same cycle.
- R9: Outside commit cycles, `ram_oe_n` is 0, `ram_we_n` is 1 and `ram_addr` follows the sequencer address.
- R10: The shared data bus is never driven by the store and by the data holding registers in the same cycle.
- R11: An offset-3 write made during a commit cycle leaves `commit_pending` at 1. The newer data is then committed in a later idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_idle | input | 1 | Sequencer is not fetching this cycle |
| seq_routine | input | 3 | Routine number of the fetch address |
| seq_step | input | 8 | Step index of the fetch address |
| seq_rdata | output | 16 | Fetched microcode word |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| commit_pending | output | 1 | Held word is waiting for an idle cycle |
| ram_addr | output | 11 | Store address after the multiplexer |
| ram_oe_n | output | 1 | Store output enable, active low |
| ram_we_n | output | 1 | Store write enable, active low |

## Verification
The bench builds the block with its default parameters. These are an 8-bit step, a 3-bit routine number, two byte halves and a 512-byte host window at 0x0200. With these values, both ends of the routine range and a mirrored register alias at 0x0300 can be reached. Writes just below and above the window are also covered. Commits are held back by runs of busy sequencer cycles, and one commit overlaps a fresh high-byte write to show that the pending flag is re-armed.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  typedef enum logic [1:0] {
    HREG_STEP    = 2'd0,
    HREG_ROUTINE = 2'd1,
    HREG_DLO     = 2'd2,
    HREG_DHI     = 2'd3
  } hold_reg_e;
endpackage

// File: rtl/ucode_host_regs.sv
module ucode_host_regs #(
  parameter int unsigned               HOST_AW  = 16,
  parameter logic [HOST_AW-1:0]        WIN_BASE = 16'h0200,
  parameter int unsigned               WIN_LOG2 = 9,
  parameter int unsigned               STEP_W   = 8,
  parameter int unsigned               SEL_W    = 3,
  parameter int unsigned               HALF_W   = 8,
  parameter int unsigned               HALVES   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [HOST_AW-1:0]         addr,
  input  logic [HALF_W-1:0]          wdata,
  input  logic                       commit,
  output logic [STEP_W-1:0]          step_q,
  output logic [SEL_W-1:0]           sel_q,
  output logic [HALVES*HALF_W-1:0]   data_q,
  output logic                       pending_q
);
  import ucode_pkg::*;

  logic       in_win;
  logic       wr_hit;
  logic [1:0] offs;
  logic       hi_wr;

  assign in_win = (addr[HOST_AW-1:WIN_LOG2] == WIN_BASE[HOST_AW-1:WIN_LOG2]);
  assign wr_hit = wr_en && in_win;
  assign offs   = addr[1:0];
  assign hi_wr  = wr_hit && (offs == HREG_DHI);

  // address holding registers
  logic [STEP_W-1:0] step_d;
  logic [SEL_W-1:0]  sel_d;

  always_comb begin
    step_d = step_q;
    sel_d  = sel_q;
    if (wr_hit && offs == HREG_STEP)    step_d = wdata[STEP_W-1:0];
    if (wr_hit && offs == HREG_ROUTINE) sel_d  = wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      sel_q  <= '0;
    end else begin
      step_q <= step_d;
      sel_q  <= sel_d;
    end
  end

  // data holding registers, one per byte half
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [1:0] HOFF = 2'(int'(HREG_DLO) + h);
    logic              ld;
    logic [HALF_W-1:0] half_d;
    logic [HALF_W-1:0] half_q;

    assign ld = wr_hit && (offs == HOFF);

    always_comb begin
      half_d = half_q;
      if (ld) half_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= '0;
      else        half_q <= half_d;
    end

    assign data_q[h*HALF_W +: HALF_W] = half_q;
  end

  // commit request flag
  logic pending_d;

  always_comb begin
    pending_d = pending_q;
    if (commit) pending_d = 1'b0;
    if (hi_wr)  pending_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= pending_d;
  end
endmodule

// File: rtl/ucode_arbiter.sv
module ucode_arbiter (
  input  logic seq_idle,
  input  logic pending,
  output logic commit,
  output logic sel_seq,
  output logic oe_n,
  output logic we_n
);
  always_comb begin
    commit  = pending && seq_idle;
    sel_seq = !commit;
    oe_n    = commit;
    we_n    = !commit;
  end
endmodule

// File: rtl/ucode_addr_mux.sv
module ucode_addr_mux #(
  parameter int unsigned AW = 11
) (
  input  logic          sel_seq,
  input  logic [AW-1:0] seq_addr,
  input  logic [AW-1:0] host_addr,
  output logic [AW-1:0] mux_addr
);
  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign mux_addr[b] = sel_seq ? seq_addr[b] : host_addr[b];
  end
endmodule

// File: rtl/ucode_store.sv
module ucode_store #(
  parameter int unsigned AW     = 11,
  parameter int unsigned HALF_W = 8,
  parameter int unsigned HALVES = 2
) (
  input  logic                      clk,
  input  logic                      oe_n,
  input  logic                      we_n,
  input  logic [AW-1:0]             addr,
  input  logic [HALVES*HALF_W-1:0]  din,
  output logic [HALVES*HALF_W-1:0]  dout,
  output logic [HALVES*HALF_W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar h = 0; h < HALVES; h++) begin : g_chip
    logic [HALF_W-1:0] mem [DEPTH];
    logic [HALF_W-1:0] rd_q;

    // the array drives the bus only while its output is enabled
    assign dout[h*HALF_W +: HALF_W] = (!oe_n && we_n) ? mem[addr] : '0;

    always_ff @(posedge clk) begin
      if (!we_n) mem[addr] <= din[h*HALF_W +: HALF_W];
    end

    always_ff @(posedge clk) begin
      if (!oe_n) rd_q <= mem[addr];
    end

    assign rdata[h*HALF_W +: HALF_W] = rd_q;
  end
endmodule

// File: rtl/ucode_share_ctrl.sv
module ucode_share_ctrl #(
  parameter int unsigned        STEP_W   = 8,
  parameter int unsigned        SEL_W    = 3,
  parameter int unsigned        HALF_W   = 8,
  parameter int unsigned        HOST_AW  = 16,
  parameter logic [HOST_AW-1:0] WIN_BASE = 16'h0200,
  parameter int unsigned        WIN_LOG2 = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seq_idle,
  input  logic [SEL_W-1:0]           seq_routine,
  input  logic [STEP_W-1:0]          seq_step,
  output logic [2*HALF_W-1:0]        seq_rdata,
  input  logic                       host_wr_en,
  input  logic [HOST_AW-1:0]         host_addr,
  input  logic [HALF_W-1:0]          host_wdata,
  output logic                       commit_pending,
  output logic [SEL_W+STEP_W-1:0]    ram_addr,
  output logic                       ram_oe_n,
  output logic                       ram_we_n
);
  localparam int unsigned HALVES = 2;
  localparam int unsigned WORD_W = HALVES * HALF_W;
  localparam int unsigned AW     = SEL_W + STEP_W;

  logic [STEP_W-1:0] h_step;
  logic [SEL_W-1:0]  h_sel;
  logic [WORD_W-1:0] h_data;
  logic              commit;
  logic              sel_seq;
  logic              bus_from_ram;
  logic              bus_from_regs;
  logic [WORD_W-1:0] ram_dout;
  logic [WORD_W-1:0] dbus;

  ucode_host_regs #(
    .HOST_AW(HOST_AW), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .STEP_W(STEP_W), .SEL_W(SEL_W), .HALF_W(HALF_W), .HALVES(HALVES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
    .wdata(host_wdata), .commit(commit), .step_q(h_step), .sel_q(h_sel),
    .data_q(h_data), .pending_q(commit_pending)
  );

  ucode_arbiter u_arb (
    .seq_idle(seq_idle), .pending(commit_pending), .commit(commit),
    .sel_seq(sel_seq), .oe_n(ram_oe_n), .we_n(ram_we_n)
  );

  ucode_addr_mux #(.AW(AW)) u_mux (
    .sel_seq(sel_seq), .seq_addr({seq_routine, seq_step}),
    .host_addr({h_sel, h_step}), .mux_addr(ram_addr)
  );

  // shared data bus: store output or data holding registers
  assign bus_from_ram  = !ram_oe_n && ram_we_n;
  assign bus_from_regs = commit;
  assign dbus = bus_from_regs ? h_data : ram_dout;

  ucode_store #(.AW(AW), .HALF_W(HALF_W), .HALVES(HALVES)) u_store (
    .clk(clk), .oe_n(ram_oe_n), .we_n(ram_we_n), .addr(ram_addr),
    .din(dbus), .dout(ram_dout), .rdata(seq_rdata)
  );
endmodule

// File: rtl/ucode_share_chk.sv
module ucode_share_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seq_idle,
  input logic [AW-1:0] seq_addr,
  input logic          host_wr_en,
  input logic          commit_pending,
  input logic [AW-1:0] ram_addr,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic          bus_ram,
  input logic          bus_regs
);
  AST_WE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> seq_idle); // R6
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pending && !seq_idle) |=> commit_pending); // R6
  AST_WE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (commit_pending && ram_oe_n)); // R7
  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && !host_wr_en) |=> !commit_pending); // R8
  AST_SEQ_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_n |-> (ram_addr == seq_addr && !ram_oe_n)); // R9
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bus_ram, bus_regs}) <= 1); // R10
endmodule

bind ucode_share_ctrl ucode_share_chk #(.AW(SEL_W + STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle),
  .seq_addr({seq_routine, seq_step}), .host_wr_en(host_wr_en),
  .commit_pending(commit_pending), .ram_addr(ram_addr),
  .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
  .bus_ram(bus_from_ram), .bus_regs(bus_from_regs)
);

// File: tb/tb_ucode_share_ctrl.sv
module tb_ucode_share_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seq_idle;
  logic [2:0]  seq_routine;
  logic [7:0]  seq_step;
  logic [15:0] seq_rdata;
  logic        host_wr_en;
  logic [15:0] host_addr;
  logic [7:0]  host_wdata;
  logic        commit_pending;
  logic [10:0] ram_addr;
  logic        ram_oe_n;
  logic        ram_we_n;

  int n_chk = 0;
  int n_bad = 0;
  int busy_writes = 0;
  int bus_fights = 0;
  bit mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_share_ctrl dut (
    .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .seq_routine(seq_routine),
    .seq_step(seq_step), .seq_rdata(seq_rdata), .host_wr_en(host_wr_en),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .commit_pending(commit_pending), .ram_addr(ram_addr),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // port monitor
  always @(negedge clk) begin
    #1;
    if (mon_on && rst_n) begin
      if (!ram_we_n && !seq_idle) busy_writes++;
      if (!ram_we_n && !ram_oe_n) bus_fights++;
    end
  end

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic read_word(input logic [2:0] r, input logic [7:0] s, output logic [15:0] w);
    @(negedge clk);
    seq_routine = r; seq_step = s;
    @(negedge clk);
    #1 w = seq_rdata;
  endtask

  task automatic t_reset;
    #1;
    chk(commit_pending == 1'b0, "R1 pending", 32'(commit_pending), 0);
    chk(ram_we_n == 1'b1,      "R1 we_n",    32'(ram_we_n), 1);
    chk(ram_oe_n == 1'b0,      "R1 oe_n",    32'(ram_oe_n), 0);
  endtask

  task automatic t_idle_commit;
    logic [15:0] w;
    seq_idle = 1'b1;
    host_write(16'h0200, 8'h3C);
    host_write(16'h0201, 8'h05);
    host_write(16'h0202, 8'hEF);
    host_write(16'h0203, 8'hBE);
    #1;
    chk(commit_pending == 1'b1, "R5 pending set", 32'(commit_pending), 1);
    chk(ram_we_n == 1'b0 && ram_oe_n == 1'b1, "R7 strobes", {30'd0, ram_we_n, ram_oe_n}, 32'h1);
    chk(ram_addr == 11'h53C, "R7 host addr", 32'(ram_addr), 32'h53C);
    @(negedge clk); #1;
    chk(commit_pending == 1'b0, "R8 pending cleared", 32'(commit_pending), 0);
    read_word(3'd5, 8'h3C, w);
    chk(w == 16'hBEEF, "R2 R3 readback", 32'(w), 32'hBEEF);
  endtask

  task automatic t_busy_hold;
    logic [15:0] w;
    @(negedge clk);
    seq_idle = 1'b0; seq_routine = 3'd2; seq_step = 8'h10;
    host_write(16'h0300, 8'h77);   // mirrored alias of offset 0
    host_write(16'h0301, 8'hFB);   // only bits 2:0 kept -> routine 3
    host_write(16'h0302, 8'h34);
    host_write(16'h0303, 8'h12);
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(commit_pending == 1'b1, "R6 held while busy", 32'(commit_pending), 1);
      chk(ram_we_n == 1'b1 && ram_oe_n == 1'b0, "R9 read strobes", {30'd0, ram_we_n, ram_oe_n}, 32'h2);
      chk(ram_addr == 11'h210, "R9 seq addr", 32'(ram_addr), 32'h210);
      @(negedge clk);
    end
    seq_idle = 1'b1;
    #1;
    chk(ram_we_n == 1'b0 && ram_addr == 11'h377, "R6 R7 commit in idle", 32'(ram_addr), 32'h377);
    @(negedge clk); #1;
    chk(commit_pending == 1'b0, "R8 cleared after idle", 32'(commit_pending), 0);
    read_word(3'd3, 8'h77, w);
    chk(w == 16'h1234, "R3 mirror readback", 32'(w), 32'h1234);
  endtask

  task automatic t_outside;
    logic [15:0] w;
    seq_idle = 1'b1;
    host_write(16'h0202, 8'h11);
    host_write(16'h0402, 8'h99);
    host_write(16'h0603, 8'h55);
    host_write(16'h01FF, 8'h66);
    #1;
    chk(commit_pending == 1'b0, "R4 no arm outside", 32'(commit_pending), 0);
    host_write(16'h0200, 8'h01);
    host_write(16'h0201, 8'h00);
    host_write(16'h0203, 8'h22);
    @(negedge clk);
    read_word(3'd0, 8'h01, w);
    chk(w == 16'h2211, "R4 low byte untouched", 32'(w), 32'h2211);
  endtask

  task automatic t_rearm;
    logic [15:0] w;
    @(negedge clk);
    seq_idle = 1'b0;
    host_write(16'h0200, 8'h80);
    host_write(16'h0201, 8'h07);
    host_write(16'h0202, 8'hAA);
    host_write(16'h0203, 8'h01);
    @(negedge clk);
    seq_idle = 1'b1;
    host_wr_en = 1'b1; host_addr = 16'h0203; host_wdata = 8'h02;
    #1;
    chk(ram_we_n == 1'b0, "R11 first commit", 32'(ram_we_n), 0);
    @(negedge clk);
    host_wr_en = 1'b0;
    #1;
    chk(commit_pending == 1'b1, "R11 re-armed", 32'(commit_pending), 1);
    @(negedge clk); #1;
    chk(commit_pending == 1'b0, "R11 second commit done", 32'(commit_pending), 0);
    read_word(3'd7, 8'h80, w);
    chk(w == 16'h02AA, "R11 newer data stored", 32'(w), 32'h02AA);
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0; seq_idle = 1'b0; seq_routine = '0; seq_step = '0;
        host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        mon_on = 1'b1;
        t_idle_commit();
        t_busy_hold();
        t_outside();
        t_rearm();
        @(negedge clk);
        chk(busy_writes == 0, "R6 no write while busy", 32'(busy_writes), 0);
        chk(bus_fights == 0, "R10 no bus fight", 32'(bus_fights), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule